// File: doc/BRIEF.md
# Expression Tree Evaluator with On-Chip Call Stack

This block evaluates arithmetic expression trees that live in a shared, word-addressed heap. A host loads a pointer to the tree root and a pointer to an environment array, then pulses `start`. The block fetches nodes through a single read port that allows one outstanding request at a time, and it returns a 31-bit signed result with `rdy`. When the tree cannot be evaluated, it returns an error code instead of a result.

Three node kinds are handled: a literal integer, a variable that selects one element of the environment array, and a two-operand sum. The recursion that nested sums need is turned into iteration over a small stack held in local RAM. Each entry of that stack holds a pending step: either "evaluate this right operand next" or "add this saved left value". No heap traffic is needed to save or restore partial work. The stack depth is bounded, and a sum node met while the stack is full ends the run with an overflow code.

Top module: `tree_eval`

## Requirements
- R1: After an accepted `start` in idle, `rdy` is low from the next cycle. When the run ends, `rdy` rises and `rdy`, `status` and `result` hold until the next accepted `start`.
- R2: `status` reads 0 for success, 1 for an evaluation failure and 2 for stack overflow, and it is valid while `rdy` is high. On any error `result` is 0.
- R3: A node at word address p has a header at p whose bits [7:0] give the kind: 0 literal, 1 variable, 2 sum. A literal stores the encoded word 2n+1 at p+1 and evaluates to n.
- R4: A variable stores the encoded index 2i+1 at p+1. The environment word at `env_ptr` holds the element count as a plain unsigned number. Element i sits at `env_ptr`+1+i, encoded as 2n+1, and the variable evaluates to that n.
- R5: Each sum node pushes one stack entry. A sum header read while DEPTH entries are live ends the run with status 2. A tree whose sum nesting never exceeds DEPTH entries succeeds.
- R6: A variable index below 0, or at or above the element count, ends the run with status 1. So does a header kind above 2, anywhere in the tree.
- R7: `mem_req` stays high with `mem_addr` stable until `mem_valid` is seen. The result does not depend on the read latency.
- R8: A sum node stores its left pointer at p+1 and its right pointer at p+2. The left operand is fetched and evaluated before the right. The sum wraps modulo 2^31.
- R9: `start` is ignored while a run is in progress, and `mem_req` is low while idle.
- R10: An asynchronous active-low reset forces `rdy`, `status`, `result` and `mem_req` to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin evaluation (taken only in idle) |
| root_ptr | input | AW | Word address of the root node |
| env_ptr | input | AW | Word address of the environment array header |
| rdy | output | 1 | Run finished; status and result valid |
| status | output | 2 | 0 ok, 1 failure, 2 stack overflow |
| result | output | 31 | Signed result value |
| mem_req | output | 1 | Read request, held until mem_valid |
| mem_addr | output | AW | Read word address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
If the stack pointer or a saved continuation is wrong, the error shows up at the ports when the affected subtree returns. The symptom is a wrong sum, a spurious overflow code, or a read of the wrong heap address. It appears within the few reads that follow the bad pop. A wrong state decode shows up sooner, in the very next `mem_addr`, or as a `mem_req` that drops before `mem_valid` arrives. Bound and tag errors are checked by the final status. The order of left and right evaluation is checked by the order in which the leaf headers are read.

// File: rtl/tree_eval.sv
module tree_eval #(
  parameter int AW    = 16,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] root_ptr,
  input  logic [AW-1:0] env_ptr,
  output logic          rdy,
  output logic [1:0]    status,
  output logic [30:0]   result,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [31:0]   mem_rdata
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = $clog2(DEPTH);
  localparam int EW  = 1 + AW + 31;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_LIT, S_VIDX, S_VLEN, S_VELEM, S_LEFT, S_RIGHT, S_RET, S_POP
  } st_t;

  st_t            state;
  logic [AW-1:0]  ptr, lptr, env;
  logic [30:0]    idx, val;
  logic [SPW-1:0] sp;
  logic [EW-1:0]  ram [DEPTH];
  logic [EW-1:0]  top_q, wdata;
  logic [IW-1:0]  waddr, rd_idx;
  logic           we, got;
  logic [7:0]     tag;

  logic           top_add;
  logic [AW-1:0]  top_ptr;
  logic [30:0]    top_val;

  assign {top_add, top_ptr, top_val} = top_q;
  assign tag     = mem_rdata[7:0];
  assign mem_req = state inside {S_HDR, S_LIT, S_VIDX, S_VLEN, S_VELEM, S_LEFT, S_RIGHT};
  assign got     = mem_req && mem_valid;
  logic [SPW-1:0] sp_m1;
  assign sp_m1   = sp - SPW'(1);
  assign rd_idx  = sp_m1[IW-1:0];

  always_comb begin
    case (state)
      S_HDR:   mem_addr = ptr;
      S_RIGHT: mem_addr = ptr + AW'(2);
      S_VLEN:  mem_addr = env;
      S_VELEM: mem_addr = env + AW'(1) + idx[AW-1:0];
      default: mem_addr = ptr + AW'(1);
    endcase
  end

  always_comb begin
    we    = 1'b0;
    waddr = sp[IW-1:0];
    wdata = {1'b0, mem_rdata[AW-1:0], 31'd0};
    if (state == S_RIGHT && got) begin
      we = 1'b1;
    end else if (state == S_POP && !top_add) begin
      we    = 1'b1;
      waddr = rd_idx;
      wdata = {1'b1, top_ptr, val};
    end
  end

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    top_q <= ram[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      rdy    <= 1'b0;
      status <= 2'd0;
      result <= '0;
      ptr    <= '0;
      lptr   <= '0;
      env    <= '0;
      idx    <= '0;
      val    <= '0;
      sp     <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          ptr   <= root_ptr;
          env   <= env_ptr;
          sp    <= '0;
          rdy   <= 1'b0;
          state <= S_HDR;
        end
        S_HDR: if (got) begin
          case (tag)
            8'd0: state <= S_LIT;
            8'd1: state <= S_VIDX;
            8'd2: begin
              if (sp == SPW'(DEPTH)) begin
                rdy <= 1'b1; status <= 2'd2; result <= '0; state <= S_IDLE;
              end else begin
                state <= S_LEFT;
              end
            end
            default: begin
              rdy <= 1'b1; status <= 2'd1; result <= '0; state <= S_IDLE;
            end
          endcase
        end
        S_LIT: if (got) begin
          val   <= mem_rdata[31:1];
          state <= S_RET;
        end
        S_VIDX: if (got) begin
          idx   <= mem_rdata[31:1];
          state <= S_VLEN;
        end
        S_VLEN: if (got) begin
          if (!idx[30] && ({1'b0, idx} < mem_rdata)) begin
            state <= S_VELEM;
          end else begin
            rdy <= 1'b1; status <= 2'd1; result <= '0; state <= S_IDLE;
          end
        end
        S_VELEM: if (got) begin
          val   <= mem_rdata[31:1];
          state <= S_RET;
        end
        S_LEFT: if (got) begin
          lptr  <= mem_rdata[AW-1:0];
          state <= S_RIGHT;
        end
        S_RIGHT: if (got) begin
          sp    <= sp + SPW'(1);
          ptr   <= lptr;
          state <= S_HDR;
        end
        S_RET: begin
          if (sp == '0) begin
            rdy <= 1'b1; status <= 2'd0; result <= val; state <= S_IDLE;
          end else begin
            state <= S_POP;
          end
        end
        S_POP: begin
          if (!top_add) begin
            ptr   <= top_ptr;
            state <= S_HDR;
          end else begin
            val   <= top_val + val;
            sp    <= sp_m1;
            state <= S_RET;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tree_eval_chk.sv
module tree_eval_chk #(
  parameter int AW    = 16,
  parameter int DEPTH = 64,
  parameter int SPW   = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           rdy,
  input logic [1:0]     status,
  input logic           mem_req,
  input logic           mem_valid,
  input logic [AW-1:0]  mem_addr,
  input logic [SPW-1:0] sp
);
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> !mem_req);

  p_status_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> (status != 2'd3));

  p_stack_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(DEPTH));

  p_overflow_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && status == 2'd2) |-> (sp == SPW'(DEPTH)));

  p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && rdy) |=> !rdy);
endmodule

bind tree_eval tree_eval_chk #(.AW(AW), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .rdy(rdy), .status(status),
  .mem_req(mem_req), .mem_valid(mem_valid), .mem_addr(mem_addr), .sp(sp)
);

// File: tb/tree_eval_tb.sv
module tree_eval_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DEPTH = 4;
  localparam int ENV = 200;
  localparam int NV = 12;

  localparam int    V_ROOT [NV] = '{0, 2, 4, 7, 9, 11, 13, 18, 23, 33, 30, 50};
  localparam int    V_LAT  [NV] = '{0, 1, 2, 0, 1, 0, 3, 1, 0, 2, 0, 1};
  localparam int    V_ST   [NV] = '{0, 0, 0, 1, 1, 1, 0, 1, 0, 0, 2, 0};
  localparam int    V_RES  [NV] = '{5, -3, 2, 0, 0, 0, 1002, 0, -1073741820, 25, 0, 4};
  localparam string V_TAG  [NV] = '{"R3", "R4", "R8", "R6", "R6", "R6", "R7",
                                    "R6", "R8", "R5", "R5", "R8"};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] root_ptr = '0, env_ptr = AW'(ENV);
  logic rdy, mem_req, mem_valid;
  logic [1:0] status;
  logic [30:0] result;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_rdata;

  logic [31:0] heap [256];
  int lat = 0, cnt = 0, seq = 0, first0 = -1, first2 = -1;
  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tree_eval #(.AW(AW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .root_ptr(root_ptr), .env_ptr(env_ptr),
    .rdy(rdy), .status(status), .result(result), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_rdata <= '0;
      cnt = 0;
    end else if (mem_valid) begin
      mem_valid <= 1'b0;
    end else if (mem_req) begin
      if (cnt >= lat) begin
        mem_valid <= 1'b1;
        mem_rdata <= heap[mem_addr];
        cnt = 0;
        if (mem_addr == 0 && first0 < 0) first0 = seq;
        if (mem_addr == 2 && first2 < 0) first2 = seq;
        seq++;
      end else begin
        cnt++;
      end
    end
  end

  function automatic logic [31:0] enc(int n);
    return 32'(2 * n + 1);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
    end
  end

  task automatic pulse_start(int root);
    @(negedge clk);
    root_ptr = AW'(root);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_rdy(string req);
    for (int i = 0; i < 3000; i++) begin
      if (rdy) return;
      @(negedge clk);
    end
    check(req, "rdy timeout", 0, 1);
  endtask

  task automatic run(int root, int l, string req, int est, int eres);
    lat = l;
    pulse_start(root);
    check("R1", "rdy low after start", int'(rdy), 0);
    wait_rdy(req);
    check(req, "status", int'(status), est);
    check(req, "result", int'($signed(result)), eres);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) heap[i] = 32'hFF;
    heap[ENV] = 4;
    heap[ENV+1] = enc(10); heap[ENV+2] = enc(-3);
    heap[ENV+3] = enc(7);  heap[ENV+4] = enc(1000);
    heap[0] = 0;  heap[1] = enc(5);
    heap[2] = 1;  heap[3] = enc(1);
    heap[4] = 2;  heap[5] = 0;  heap[6] = 2;
    heap[7] = 1;  heap[8] = enc(4);
    heap[9] = 1;  heap[10] = enc(-1);
    heap[11] = 3;
    heap[13] = 2; heap[14] = 4; heap[15] = 16;
    heap[16] = 1; heap[17] = enc(3);
    heap[18] = 2; heap[19] = 0; heap[20] = 11;
    heap[21] = 0; heap[22] = enc(1073741823);
    heap[23] = 2; heap[24] = 21; heap[25] = 0;
    for (int k = 0; k < 5; k++) begin
      heap[30+3*k] = 2;
      heap[31+3*k] = (k < 4) ? 32'(30 + 3*(k+1)) : 32'd0;
      heap[32+3*k] = 0;
    end
    heap[50] = 2; heap[51] = 0;  heap[52] = 53;
    heap[53] = 2; heap[54] = 2;  heap[55] = 4;

    #(CLK_PERIOD*2 + 2);
    check("R10", "rdy in reset", int'(rdy), 0);
    check("R10", "status in reset", int'(status), 0);
    check("R10", "result in reset", int'(result), 0);
    check("R10", "mem_req in reset", int'(mem_req), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R9", "mem_req idle", int'(mem_req), 0);

    for (int v = 0; v < NV; v++) begin
      seq = 0; first0 = -1; first2 = -1;
      run(V_ROOT[v], V_LAT[v], V_TAG[v], V_ST[v], V_RES[v]);
      if (V_ROOT[v] == 4) begin
        check("R8", "left leaf read first", int'(first0 >= 0 && first0 < first2), 1);
      end
    end

    repeat (5) @(negedge clk);
    check("R1", "result held", int'($signed(result)), 4);
    check("R1", "rdy held", int'(rdy), 1);
    check("R9", "mem_req idle after run", int'(mem_req), 0);

    lat = 3;
    pulse_start(13);
    repeat (4) @(negedge clk);
    start = 1'b1; root_ptr = AW'(0);
    @(negedge clk);
    start = 1'b0;
    wait_rdy("R9");
    check("R9", "busy start ignored", int'($signed(result)), 1002);

    lat = 2;
    pulse_start(6'd13);
    repeat (6) @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    check("R10", "async reset mem_req", int'(mem_req), 0);
    check("R10", "async reset rdy", int'(rdy), 0);
    @(negedge clk); rst_n = 1'b1;
    run(2, 0, "R4", 0, -3);

    finish_run();
  end
endmodule